// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block decides, once per second, whether the current time of day equals a programmed alarm time. A clock-keeping block outside it holds the current seconds, minutes and hours bytes and pulses `upd_done` when it finishes advancing the time. On that pulse the comparator checks each of the three time fields against its alarm byte. If every field agrees, the comparator sets a sticky alarm flag. When interrupts are enabled, it also raises an interrupt request.

Any alarm byte can be a wildcard, so a single comparator covers several kinds of alarm: daily, hourly, once a minute, or every second. Two format inputs, shared by the time bytes and the alarm bytes, select how the bytes are read. One chooses packed decimal or plain binary. The other chooses 12-hour or 24-hour hour encoding. Hours are normalised to 0..23 before they are compared, so the same wall-clock hour matches whichever way it is written. Software clears the flag and the request with a one-cycle acknowledge pulse.

Top module: `tod_alarm_match`

## Requirements
- R1: After reset, `alarm_flag` and `irq` are both 0.
- R2: An alarm byte whose bits 7:6 are both 1 is a wildcard. It matches every value of its field, and the other two fields must still match.
- R3: When `fmt_binary` = 0, each byte is packed decimal: bits 7:4 hold the tens digit and bits 3:0 hold the units digit. For example, 0x45 means 45.
- R4: When `fmt_binary` = 1, each byte is compared as a plain binary number. For example, 0x2D means 45, and 0x45 means 69.
- R5: When `fmt_24h` = 0, bit 7 of an hours byte marks PM. The hour value in bits 6:0 is taken modulo 12, and 12 is added when PM is set. So 12 AM is written 0x12 and equals hour 0, 12 PM is written 0x92 and equals hour 12, and 1 PM is written 0x81 and equals hour 13. Bit 7 is ignored when `fmt_24h` = 1.
- R6: When all three alarm bytes are wildcards, every accepted update pulse sets `alarm_flag`.
- R7: The comparison takes effect only on a cycle where `upd_done` = 1 and `halt` = 0. Such a cycle is an accepted update. A match sets `alarm_flag` in the following cycle. Matching bytes without an accepted update change nothing.
- R8: An accepted update that matches while `irq_en` = 1 also sets `irq` in the following cycle. A match while `irq_en` = 0 sets only `alarm_flag`.
- R9: A cycle with `flag_ack` = 1 clears `alarm_flag` and `irq` in the following cycle. If a matching accepted update occurs in the same cycle as the acknowledge, the flags are set instead.
- R10: An accepted update that does not match leaves `alarm_flag` and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte (bit 7 = PM in 12-hour mode) |
| alm_sec | input | 8 | Alarm seconds byte (bits 7:6 = 11 means wildcard) |
| alm_min | input | 8 | Alarm minutes byte (bits 7:6 = 11 means wildcard) |
| alm_hour | input | 8 | Alarm hours byte (bits 7:6 = 11 means wildcard) |
| fmt_binary | input | 1 | 1 = plain binary bytes, 0 = packed decimal bytes |
| fmt_24h | input | 1 | 1 = 24-hour encoding, 0 = 12-hour encoding with PM bit |
| halt | input | 1 | Time updates are frozen; update pulses are ignored |
| irq_en | input | 1 | Alarm interrupt enable |
| upd_done | input | 1 | One-cycle pulse at the end of each update cycle |
| flag_ack | input | 1 | One-cycle pulse that clears the flag and the request |
| alarm_flag | output | 1 | Sticky alarm-occurred flag |
| irq | output | 1 | Sticky interrupt request |

## Verification
The only state in this block is the two sticky flags, so any decoding fault shows up as a missed or spurious flag. Such a fault is visible exactly one cycle after the update pulse that exposes it. A wrong PM normalisation shows up only for the 12 o'clock hours and the PM hours. For that reason the directed cases deliberately encode the same hour both as AM and as PM. A flag that fails to clear, or that sets without an accepted update, persists and is visible at the port. The bench therefore checks after every acknowledge and after every blocked pulse.

// File: rtl/tod_alarm_match.sv
module tod_alarm_match (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic       fmt_binary,
  input  logic       fmt_24h,
  input  logic       halt,
  input  logic       irq_en,
  input  logic       upd_done,
  input  logic       flag_ack,
  output logic       alarm_flag,
  output logic       irq
);

  function automatic logic [7:0] to_num(input logic [7:0] b, input logic bin);
    return bin ? b : (({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]});
  endfunction

  function automatic logic [7:0] to_hour(input logic [7:0] b, input logic bin, input logic h24);
    logic [7:0] v;
    v = to_num({1'b0, b[6:0]}, bin);
    if (!h24) v = (v % 8'd12) + (b[7] ? 8'd12 : 8'd0);
    return v;
  endfunction

  logic any_s, any_m, any_h;
  logic eq_s, eq_m, eq_h;
  logic hit;

  assign any_s = &alm_sec[7:6];
  assign any_m = &alm_min[7:6];
  assign any_h = &alm_hour[7:6];

  assign eq_s = any_s | (to_num(alm_sec, fmt_binary) == to_num(cur_sec, fmt_binary));
  assign eq_m = any_m | (to_num(alm_min, fmt_binary) == to_num(cur_min, fmt_binary));
  assign eq_h = any_h | (to_hour(alm_hour, fmt_binary, fmt_24h) ==
                         to_hour(cur_hour, fmt_binary, fmt_24h));

  assign hit = upd_done & ~halt & eq_s & eq_m & eq_h;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_flag <= 1'b0;
      irq        <= 1'b0;
    end else if (hit) begin
      alarm_flag <= 1'b1;
      if (irq_en) irq <= 1'b1;
    end else if (flag_ack) begin
      alarm_flag <= 1'b0;
      irq        <= 1'b0;
    end
  end

endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cur_sec,
  input logic [7:0] cur_min,
  input logic [7:0] cur_hour,
  input logic [7:0] alm_sec,
  input logic [7:0] alm_min,
  input logic [7:0] alm_hour,
  input logic       fmt_binary,
  input logic       fmt_24h,
  input logic       halt,
  input logic       irq_en,
  input logic       upd_done,
  input logic       flag_ack,
  input logic       alarm_flag,
  input logic       irq
);

  // R7
  flag_rise_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(upd_done && !halt));

  // R8
  irq_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irq_en && upd_done && !halt));

  // R8
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> alarm_flag);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ack && !(upd_done && !halt)) |=> (!alarm_flag && !irq));

  // R6
  all_wild_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !halt && (&alm_sec[7:6]) && (&alm_min[7:6]) && (&alm_hour[7:6])) |=> alarm_flag);

  // R10
  no_update_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(upd_done && !halt) && !flag_ack) |=> ($stable(alarm_flag) && $stable(irq)));

endmodule

bind tod_alarm_match tod_alarm_match_chk chk_i (.*);

// File: tb/tod_alarm_match_tb_top.sv
module tod_alarm_match_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
  logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
  logic fmt_binary = 1'b0, fmt_24h = 1'b1, halt = 1'b0, irq_en = 1'b0;
  logic upd_done = 1'b0, flag_ack = 1'b0;
  logic alarm_flag, irq;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tod_alarm_match dut_i (.*);

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic pulse_update();
    @(negedge clk) upd_done = 1'b1;
    @(negedge clk) upd_done = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) flag_ack = 1'b1;
    @(negedge clk) flag_ack = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  task automatic set_alarm(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    alm_hour = h; alm_min = m; alm_sec = s;
  endtask

  task automatic try_match(input string req, input logic exp);
    ack();
    check({req, " cleared"}, alarm_flag, 1'b0);
    pulse_update();
    check(req, alarm_flag, exp);
  endtask

  task automatic t_reset();
    check("R1 flag", alarm_flag, 1'b0);
    check("R1 irq", irq, 1'b0);
  endtask

  task automatic t_bcd();
    fmt_binary = 1'b0; fmt_24h = 1'b1;
    set_time(8'h23, 8'h59, 8'h45); set_alarm(8'h23, 8'h59, 8'h45);
    try_match("R3 bcd equal", 1'b1);
    set_alarm(8'h23, 8'h59, 8'h44);
    try_match("R10 bcd sec differ", 1'b0);
    set_alarm(8'h23, 8'h58, 8'h45);
    try_match("R10 bcd min differ", 1'b0);
  endtask

  task automatic t_binary();
    fmt_binary = 1'b1; fmt_24h = 1'b1;
    set_time(8'd10, 8'd20, 8'd45); set_alarm(8'd10, 8'd20, 8'h2D);
    try_match("R4 binary equal", 1'b1);
    set_time(8'd10, 8'd20, 8'h45);
    try_match("R4 binary 0x45 is 69", 1'b0);
    fmt_binary = 1'b0;
  endtask

  task automatic t_wild();
    fmt_24h = 1'b1;
    set_time(8'h07, 8'h33, 8'h12); set_alarm(8'hC0, 8'hFF, 8'h12);
    try_match("R2 hour+min wild", 1'b1);
    set_alarm(8'hC5, 8'hC0, 8'h13);
    try_match("R2 sec still compared", 1'b0);
    set_alarm(8'hC0, 8'hC0, 8'hC0);
    ack();
    for (int i = 0; i < 3; i++) begin
      cur_sec = 8'(i);
      pulse_update();
      check("R6 every update", alarm_flag, 1'b1);
      ack();
      check("R9 ack clears", alarm_flag, 1'b0);
    end
  endtask

  task automatic t_12h();
    fmt_binary = 1'b0; fmt_24h = 1'b0;
    set_time(8'h12, 8'h00, 8'h00); set_alarm(8'h12, 8'h00, 8'h00);
    try_match("R5 12AM eq 12AM", 1'b1);
    set_time(8'h92, 8'h00, 8'h00);
    try_match("R5 12PM ne 12AM", 1'b0);
    set_time(8'h81, 8'h00, 8'h00); set_alarm(8'h81, 8'h00, 8'h00);
    try_match("R5 1PM eq 1PM", 1'b1);
    set_alarm(8'h01, 8'h00, 8'h00);
    try_match("R5 1PM ne 1AM", 1'b0);
    fmt_24h = 1'b1;
    set_time(8'h81, 8'h00, 8'h00);
    try_match("R5 24h ignores bit7", 1'b1);
  endtask

  task automatic t_gate();
    fmt_24h = 1'b1;
    set_time(8'h05, 8'h05, 8'h05); set_alarm(8'h05, 8'h05, 8'h05);
    ack();
    repeat (3) @(negedge clk);
    check("R7 no strobe no flag", alarm_flag, 1'b0);
    halt = 1'b1;
    pulse_update();
    check("R7 halt blocks", alarm_flag, 1'b0);
    halt = 1'b0;
    @(negedge clk) upd_done = 1'b1;
    @(posedge clk);
    #1 check("R7 not before edge", alarm_flag, 1'b1);
    @(negedge clk) upd_done = 1'b0;
  endtask

  task automatic t_irq();
    set_time(8'h05, 8'h05, 8'h05); set_alarm(8'h05, 8'h05, 8'h05);
    irq_en = 1'b0;
    try_match("R8 flag without enable", 1'b1);
    check("R8 no irq when disabled", irq, 1'b0);
    irq_en = 1'b1;
    try_match("R8 flag with enable", 1'b1);
    check("R8 irq when enabled", irq, 1'b1);
    set_alarm(8'h05, 8'h05, 8'h06);
    pulse_update();
    check("R10 mismatch keeps flag", alarm_flag, 1'b1);
    check("R10 mismatch keeps irq", irq, 1'b1);
    ack();
    check("R9 ack clears irq", irq, 1'b0);
    set_alarm(8'h05, 8'h05, 8'h05);
    @(negedge clk) begin upd_done = 1'b1; flag_ack = 1'b1; end
    @(negedge clk) begin upd_done = 1'b0; flag_ack = 1'b0; end
    check("R9 hit beats ack flag", alarm_flag, 1'b1);
    check("R9 hit beats ack irq", irq, 1'b1);
    irq_en = 1'b0;
    ack();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bcd();
    t_binary();
    t_wild();
    t_12h();
    t_gate();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule